// File: doc/BRIEF.md
# Serial-Loaded Wiper Code Register

This block is the digital control core of a 256-step digital potentiometer. It receives write-only 8-bit frames over a three-wire serial link with an active-low select, a serial clock and a data input. It holds the 8-bit code that drives the external resistor tap selector. There is no data-out line, so the code cannot be read back over the link.

All three serial pins are sampled by a faster system clock through two-flop synchronizers, and their edges are found on the synchronized copies. Incoming bits go into a hidden shift register. The visible wiper code changes only when the select line returns high, and only if the frame carried at least eight clock edges. A one-cycle strobe marks each commit.

The frame controller is a three-state machine. ST_IDLE waits with select high, and a select fall moves it to ST_SHIFT. ST_SHIFT collects bits on clock rises, and a select rise moves it to ST_COMMIT. ST_COMMIT lasts one cycle and loads the code if the frame was full. It then returns to ST_IDLE, or goes straight to ST_SHIFT if select has already fallen again.

Top module: `digipot_wiper_core`

## Requirements
- R1: After reset the wiper code is 0x80 and the update strobe is low.
- R2: While select is low, each serial clock rise shifts in one data bit, most significant bit first. When select rises after a frame of exactly 8 rises, the wiper code becomes the 8 bits sent.
- R3: The wiper code does not change while select stays low, even after the eighth clock rise. It changes only after select rises.
- R4: A frame with fewer than 8 clock rises leaves the wiper code unchanged and raises no strobe.
- R5: A frame with more than 8 clock rises commits the last 8 bits received.
- R6: Every frame of 8 or more rises raises the update strobe for exactly one system cycle, even when the committed value equals the old code.
- R7: Serial clock rises while select is high have no effect: the code is unchanged and no strobe is raised.
- R8: The bit count restarts at every select fall, so two short frames that together hold 8 rises do not commit.
- R9: The wiper code covers the full range 0x00 to 0xFF and holds its value between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_csn | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock; data is sampled on its rise |
| spi_mosi | input | 1 | Serial data in |
| wiper_code | output | 8 | Current wiper tap code |
| code_upd | output | 1 | One-cycle pulse on each committed frame |

## Verification
The assertions assume that every serial clock phase spans at least two system cycles. They also assume that select settles before the first clock rise and after the last one, and that data is stable across each clock rise. Under these conditions the synchronized edges arrive in order and one at a time. The stimulus holds every clock phase and every select setup and hold for four system cycles. Data changes only while the serial clock is low, so the bench stays inside these conditions.

// File: rtl/digipot_pkg.sv
package digipot_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } frame_state_t;
endpackage

// File: rtl/dp_sync.sv
module dp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= RST_VAL;
                end else begin
                    chain[s] <= (s == 0) ? din : chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/dp_frame_fsm.sv
module dp_frame_fsm
    import digipot_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    output logic [CODE_W-1:0] frame_word,
    output logic              commit_load
);
    localparam int CNT_W = $clog2(CODE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CODE_W);

    frame_state_t      state, state_nx;
    logic              cs_d, sclk_d;
    logic              cs_fall, cs_rise, sclk_rise, shift_en;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CODE_W-1:0] shreg;

    assign cs_fall   = cs_d & ~cs_s;
    assign cs_rise   = ~cs_d & cs_s;
    assign sclk_rise = sclk_s & ~sclk_d;
    assign shift_en  = (state == ST_SHIFT) && !cs_s && sclk_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cs_fall) state_nx = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = cs_fall ? ST_SHIFT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        frame_word  = shreg;
        commit_load = (state == ST_COMMIT) && (bit_cnt == CNT_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (cs_fall) begin
            bit_cnt <= '0;
        end else if (shift_en) begin
            shreg <= {shreg[CODE_W-2:0], mosi_s};
            if (bit_cnt != CNT_FULL) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // R7
    idle_clk_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && cs_s) |=> $stable(shreg));

    // R8
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (bit_cnt == '0));
endmodule

// File: rtl/dp_wiper_reg.sv
module dp_wiper_reg #(
    parameter int              CODE_W   = 8,
    parameter logic [CODE_W-1:0] RST_CODE = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] code,
    output logic              upd
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= RST_CODE;
            upd  <= 1'b0;
        end else begin
            upd <= load;
            if (load) code <= din;
        end
    end

    // R6
    one_cycle_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);
endmodule

// File: rtl/digipot_wiper_core.sv
module digipot_wiper_core #(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_csn,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic [CODE_W-1:0] wiper_code,
    output logic              code_upd
);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    logic              cs_s, sclk_s, mosi_s;
    logic [CODE_W-1:0] frame_word;
    logic              commit_load;

    dp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .din(spi_csn), .dout(cs_s));
    dp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .din(spi_sclk), .dout(sclk_s));
    dp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .din(spi_mosi), .dout(mosi_s));

    dp_frame_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
        .frame_word(frame_word), .commit_load(commit_load));

    dp_wiper_reg #(.CODE_W(CODE_W), .RST_CODE(MID_CODE)) u_wiper (
        .clk(clk), .rst_n(rst_n), .load(commit_load), .din(frame_word),
        .code(wiper_code), .upd(code_upd));

    // R3
    code_moves_with_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_code) |-> code_upd);

    // R3
    no_commit_while_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && $past(!cs_s)) |-> !commit_load);
endmodule

// File: tb/digipot_wiper_core_bench.sv
module digipot_wiper_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_csn = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_mosi = 1'b0;
    logic [7:0] wiper_code;
    logic       code_upd;

    int checks = 0;
    int errors = 0;
    int upd_cnt = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    digipot_wiper_core u_digipot_wiper_core (
        .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .wiper_code(wiper_code), .code_upd(code_upd));

    always @(negedge clk) if (code_upd) upd_cnt++;

    localparam int NV = 10;
    localparam int VN [NV] = '{8, 8, 8, 5, 12, 8, 8, 0, 9, 16};
    localparam logic [15:0] VD [NV] = '{16'h00A5, 16'h0000, 16'h00FF, 16'h0013,
        16'h0ABC, 16'h003C, 16'h003C, 16'h0000, 16'h01C3, 16'h1234};
    localparam logic [7:0] VE [NV] = '{8'hA5, 8'h00, 8'hFF, 8'hFF, 8'hBC,
        8'h3C, 8'h3C, 8'h3C, 8'hC3, 8'h34};

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic frame_bits(input int n, input logic [15:0] data);
        spi_csn = 1'b0;
        wait_cyc(4);
        for (int i = n - 1; i >= 0; i--) begin
            spi_mosi = data[i];
            wait_cyc(4);
            spi_sclk = 1'b1;
            wait_cyc(4);
            spi_sclk = 1'b0;
        end
        wait_cyc(4);
    endtask

    task automatic end_frame();
        spi_csn = 1'b1;
        wait_cyc(12);
    endtask

    initial begin
        int base;
        int exp_upd;
        wait_cyc(3);
        check("R1 reset code", wiper_code, 8'h80);
        check("R1 reset strobe", code_upd, 0);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R1 code after release", wiper_code, 8'h80);

        for (int v = 0; v < NV; v++) begin
            base = upd_cnt;
            frame_bits(VN[v], VD[v]);
            end_frame();
            exp_upd = (VN[v] >= 8) ? 1 : 0;
            // R2 R4 R5 R9 code, R6 strobe count
            check($sformatf("R2/R4/R5/R9 vector %0d code", v), wiper_code, VE[v]);
            check($sformatf("R6 vector %0d strobes", v), upd_cnt - base, exp_upd);
        end

        // R3: full frame held selected does not commit yet
        base = upd_cnt;
        frame_bits(8, 16'h005A);
        wait_cyc(12);
        check("R3 code before select rise", wiper_code, 8'h34);
        check("R3 no strobe before select rise", upd_cnt - base, 0);
        end_frame();
        check("R3 code after select rise", wiper_code, 8'h5A);

        // R7: clock toggling while deselected
        base = upd_cnt;
        for (int i = 0; i < 8; i++) begin
            spi_mosi = i[0];
            wait_cyc(4);
            spi_sclk = 1'b1;
            wait_cyc(4);
            spi_sclk = 1'b0;
        end
        wait_cyc(12);
        check("R7 code unchanged", wiper_code, 8'h5A);
        check("R7 no strobe", upd_cnt - base, 0);

        // R8: two short frames totalling 8 edges
        base = upd_cnt;
        frame_bits(5, 16'h0015);
        end_frame();
        frame_bits(3, 16'h0006);
        end_frame();
        check("R8 code unchanged", wiper_code, 8'h5A);
        check("R8 no strobe", upd_cnt - base, 0);

        // R1: reset in mid-run
        rst_n = 1'b0;
        wait_cyc(2);
        check("R1 mid-run reset code", wiper_code, 8'h80);
        rst_n = 1'b1;
        wait_cyc(4);
        frame_bits(8, 16'h0001);
        end_frame();
        check("R2 commit after reset", wiper_code, 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end
endmodule